// File: doc/BRIEF.md
# Two-Phase Alternating PWM Steering Logic

This block is the digital steering core of a two-phase peak-current-mode buck controller. An oscillator provides a one-clock tick. Each tick opens an on-period on the next phase in rotation. A single current-comparator trip input closes whichever on-period is open. Because the ticks alternate between the two outputs, each output runs at half the tick rate. Its duty cycle therefore never exceeds 50%, and the two outputs are never high together.

The comparator trip arrives asynchronously and is resynchronized with two flops before use. An enable input parks both outputs low and rewinds the rotation. A programmable maximum on-time, counted in clock cycles, ends any on-period that sees no trip. A phase indicator reports which output was started most recently.

Top module: `twophase_pwm_steer`

## Requirements
- R1: When `en` is high and `tick` is sampled high at a clock edge, exactly one of `pwm1`/`pwm2` is high from that edge onward.
- R2: Ticks alternate the started output: PWM1, then PWM2, then PWM1 again, and so on. After reset or a disable, the first tick starts PWM1. `last_phase` shows the output most recently started, with 0 meaning PWM1 and 1 meaning PWM2.
- R3: The single `trip_async` input ends the on-period of whichever output is high. If it is driven high before clock edge n, the high output is low after edge n+2. The two-flop synchronizer accounts for that delay.
- R4: `pwm1` and `pwm2` are never high in the same cycle. If a tick arrives while one output is still high, that output goes low at the same edge that the other goes high.
- R5: A synchronized trip that coincides with a tick ends only the previous on-period. The newly started output stays high after the following edge.
- R6: A trip that arrives while both outputs are low is ignored. Both outputs stay low, and the next on-period has its normal length.
- R7: While `en` is low, both outputs are low from the next edge. The rotation is rewound, so the first tick after re-enabling starts PWM1.
- R8: With `max_on` = M > 0 and no trip, an on-period lasts exactly M clock cycles. With M = 0 the guard is off. When both a trip and the guard apply, the on-period ends at whichever comes first.
- R9: After reset, both outputs are low and `last_phase` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable; low forces both outputs low and rewinds the rotation |
| tick | input | 1 | One-cycle oscillator tick |
| trip_async | input | 1 | Shared current-comparator trip, asynchronous |
| max_on | input | CNT_W | Maximum on-time in clock cycles, 0 disables the guard |
| pwm1 | output | 1 | Phase 1 PWM output |
| pwm2 | output | 1 | Phase 2 PWM output |
| last_phase | output | 1 | Most recently started phase (0 = PWM1, 1 = PWM2) |

## Verification
A tick can land in the same cycle as the end of the previous on-period. The end may come from a synchronized trip or from the previous output still being high. The bench provokes the trip case by driving a one-cycle trip pulse exactly two edges before the tick. It provokes the still-high case by ticking with the guard off and no trip. In both cases it judges that the old output falls and the new one rises at the same edge, and that the new output is still high one cycle later. A sweep over guard lengths and trip delays checks each on-period width against the smaller of the trip latency and the guard.

// File: rtl/twophase_pwm_steer.sv
module twophase_pwm_steer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             trip_async,
  input  logic [CNT_W-1:0] max_on,
  output logic             pwm1,
  output logic             pwm2,
  output logic             last_phase
);

  logic [1:0]       sync_q;
  logic             trip_s;
  logic             nxt;
  logic [CNT_W-1:0] on_cnt;
  logic             active;
  logic             guard_hit;

  assign trip_s    = sync_q[1];
  assign active    = pwm1 | pwm2;
  assign guard_hit = (max_on != '0) && (on_cnt >= max_on);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], trip_async};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm1       <= 1'b0;
      pwm2       <= 1'b0;
      nxt        <= 1'b0;
      last_phase <= 1'b0;
      on_cnt     <= '0;
    end else if (!en) begin
      pwm1   <= 1'b0;
      pwm2   <= 1'b0;
      nxt    <= 1'b0;
      on_cnt <= '0;
    end else if (tick) begin
      pwm1       <= ~nxt;
      pwm2       <= nxt;
      last_phase <= nxt;
      nxt        <= ~nxt;
      on_cnt     <= CNT_W'(1);
    end else if (active && (trip_s || guard_hit)) begin
      pwm1   <= 1'b0;
      pwm2   <= 1'b0;
      on_cnt <= '0;
    end else if (active && on_cnt != '1) begin
      on_cnt <= on_cnt + CNT_W'(1);
    end
  end

  // R4
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(pwm1 && pwm2));

  // R1
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick) |=> (pwm1 ^ pwm2));

  // R2
  alt12_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && pwm1) |=> (pwm2 && !pwm1));

  // R2
  alt21_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && pwm2) |=> (pwm1 && !pwm2));

  // R7
  dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm1 && !pwm2));

  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm1 && !pwm2 && !(en && tick)) |=> (!pwm1 && !pwm2));

  // R8
  guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && active && !tick && guard_hit) |=> (!pwm1 && !pwm2));

endmodule

// File: tb/tb_twophase_pwm_steer.sv
module tb_twophase_pwm_steer;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, tick = 1'b0, trip_async = 1'b0;
  logic [CW-1:0] max_on = '0;
  logic pwm1, pwm2, last_phase;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit exp_ph = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twophase_pwm_steer #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .trip_async(trip_async),
    .max_on(max_on), .pwm1(pwm1), .pwm2(pwm2), .last_phase(last_phase));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // R4: mutual exclusion monitored every cycle
  always @(negedge clk)
    if (rst_n && !done) check(!(pwm1 && pwm2), "R4", {pwm2, pwm1}, 0);

  function automatic int exp_code(input bit ph);
    return ph ? 2 : 1;
  endfunction

  task automatic do_tick();
    tick = 1'b1;
    step();
    tick = 1'b0;
  endtask

  // Start one phase; trip raised j cycles after start (0 = none); check width
  task automatic run_phase(input int j, input int mo);
    int w, k, e;
    max_on = CW'(mo);
    do_tick();
    check({pwm2, pwm1} == exp_code(exp_ph), "R1", {pwm2, pwm1}, exp_code(exp_ph));
    check(last_phase == exp_ph, "R2", last_phase, exp_ph);
    exp_ph = ~exp_ph;
    w = 1;
    k = 1;
    forever begin
      if (k == j) trip_async = 1'b1;
      step();
      k++;
      if (pwm1 || pwm2) w++;
      else break;
      if (k > 300) break;
    end
    trip_async = 1'b0;
    repeat (4) step();
    if (j == 0)       e = mo;
    else if (mo == 0) e = j + 2;
    else              e = (j + 2 < mo) ? j + 2 : mo;
    if (j == 0)       check(w == e, "R8", w, e);
    else if (mo == 0) check(w == e, "R3", w, e);
    else              check(w == e, "R8", w, e);
  endtask

  task automatic end_by_trip();
    trip_async = 1'b1;
    repeat (4) step();
    trip_async = 1'b0;
    check(!pwm1 && !pwm2, "R3", {pwm2, pwm1}, 0);
    repeat (4) step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R9 reset state
    check(!pwm1 && !pwm2, "R9", {pwm2, pwm1}, 0);
    check(last_phase == 1'b0, "R9", last_phase, 0);
    rst_n = 1'b1;
    step();
    en = 1'b1;
    step();

    // R3 and R8 sweep over guard lengths and trip delays
    for (int mo = 0; mo <= 6; mo++)
      for (int j = 0; j <= 6; j++)
        if (!(mo == 0 && j == 0)) run_phase(j, mo);

    // R6: trip while idle is ignored
    trip_async = 1'b1;
    repeat (5) step();
    check(!pwm1 && !pwm2, "R6", {pwm2, pwm1}, 0);
    trip_async = 1'b0;
    repeat (4) step();
    run_phase(2, 0);

    // R4: tick while the previous phase is still high
    max_on = '0;
    do_tick();
    exp_ph = ~exp_ph;
    repeat (2) step();
    do_tick();
    check({pwm2, pwm1} == exp_code(exp_ph), "R4", {pwm2, pwm1}, exp_code(exp_ph));
    exp_ph = ~exp_ph;
    end_by_trip();

    // R5: synchronized trip coincides with a tick
    do_tick();
    exp_ph = ~exp_ph;
    step();
    trip_async = 1'b1;
    step();
    trip_async = 1'b0;
    step();
    tick = 1'b1;
    step();
    tick = 1'b0;
    check({pwm2, pwm1} == exp_code(exp_ph), "R5", {pwm2, pwm1}, exp_code(exp_ph));
    step();
    check({pwm2, pwm1} == exp_code(exp_ph), "R5", {pwm2, pwm1}, exp_code(exp_ph));
    exp_ph = ~exp_ph;
    end_by_trip();

    // R7: disable mid-phase rewinds the rotation
    if (exp_ph) run_phase(2, 0);
    do_tick();
    check(pwm1 && !pwm2, "R7", {pwm2, pwm1}, 1);
    step();
    en = 1'b0;
    step();
    check(!pwm1 && !pwm2, "R7", {pwm2, pwm1}, 0);
    repeat (3) step();
    do_tick();
    check(!pwm1 && !pwm2, "R7", {pwm2, pwm1}, 0);
    en = 1'b1;
    repeat (2) step();
    exp_ph = 1'b0;
    run_phase(3, 0);
    run_phase(1, 4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule